// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset and a 16-bit segment base into a 20-bit physical byte address. It holds four segment registers (extra, code, stack, data). From the access kind presented each cycle it either uses a fixed pointer (instruction pointer, stack pointer, string destination index) or builds an effective address. That address is the sum of up to two register operands and an optional displacement. The segment base is shifted left by four bits and added to the offset, so segments can span 64 KiB each and may overlap.

For ordinary data operands the block picks the default segment from the registers involved. Any use of the frame base selects the stack segment, and every other form selects the data segment. An explicit override input can replace that default. Two base registers or two index registers in one address is an illegal pairing. The block flags it and drives both address outputs to zero. All results are registered, so a request presented in one cycle has its answer on the outputs after the next rising clock edge.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address is (segment value × 16 + offset) modulo 2^20 (for example 6000h:0010h gives 60010h and 448Ah:1234h gives 45AD4h). It is registered and appears after the rising edge that samples the request.
- R2: For a data operand (kind 0) the effective address is (value of operand A + value of operand B + displacement when disp_en=1) modulo 2^16. Operand codes are 0 none, 1 general base, 2 frame base, 3 source index, 4 destination index, and 5 to 7 none.
- R3: A data operand whose operand A or operand B is the frame base (code 2) defaults to the stack segment. Any other data operand, including a displacement alone, defaults to the data segment.
- R4: For a data operand with ovr_en=1, the segment named by ovr_sel replaces the default. Segment select codes are 0 extra, 1 code, 2 stack, 3 data.
- R5: A data operand that pairs two base registers (codes 1/2 with 1/2) or two index registers (codes 3/4 with 3/4) sets bad_mode. Both address outputs are then zero.
- R6: Kind 1 (instruction fetch) uses the code segment with reg_ip as offset. The override is ignored and bad_mode stays 0.
- R7: Kind 2 (stack access) uses the stack segment with reg_sp as offset. The override is ignored and bad_mode stays 0.
- R8: Kind 3 (string destination) uses the extra segment with reg_didx as offset. The override is ignored and bad_mode stays 0.
- R9: A segment write with seg_wr_en=1 stores seg_wr_data into the register named by seg_wr_sel at the clock edge. A request in the same cycle still sees the old value, and one in the next cycle sees the new value.
- R10: A synchronous reset clears all segment registers and drives phys_addr, eff_addr and bad_mode to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_sel | input | 2 | Segment to write (0 extra, 1 code, 2 stack, 3 data) |
| seg_wr_data | input | 16 | Segment write value |
| kind | input | 2 | Access kind: 0 data, 1 fetch, 2 stack, 3 string destination |
| op_a | input | 3 | First register operand code |
| op_b | input | 3 | Second register operand code |
| disp_en | input | 1 | Add displacement |
| disp | input | 16 | Displacement |
| reg_gbase | input | 16 | General base register value |
| reg_fbase | input | 16 | Frame base register value |
| reg_sidx | input | 16 | Source index register value |
| reg_didx | input | 16 | Destination index register value |
| reg_ip | input | 16 | Instruction pointer |
| reg_sp | input | 16 | Stack pointer |
| ovr_en | input | 1 | Segment override valid |
| ovr_sel | input | 2 | Override segment select |
| phys_addr | output | 20 | Physical byte address |
| eff_addr | output | 16 | Effective address (offset) |
| bad_mode | output | 1 | Illegal register pairing |

## Verification
Every address result and the bad_mode flag are due exactly one rising edge after the request is presented. A segment write becomes visible to requests made in the cycle after the writing edge. The bench drives each request shortly after a rising edge, waits for the next edge, and samples one time unit later. It therefore always reads the answer to the request just presented. Same-cycle write-and-read is checked against the old segment value, and the following cycle against the new one.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OFS_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     seg_wr_en,
  input  logic [1:0]               seg_wr_sel,
  input  logic [OFS_W-1:0]         seg_wr_data,
  input  logic [1:0]               kind,
  input  logic [2:0]               op_a,
  input  logic [2:0]               op_b,
  input  logic                     disp_en,
  input  logic [OFS_W-1:0]         disp,
  input  logic [OFS_W-1:0]         reg_gbase,
  input  logic [OFS_W-1:0]         reg_fbase,
  input  logic [OFS_W-1:0]         reg_sidx,
  input  logic [OFS_W-1:0]         reg_didx,
  input  logic [OFS_W-1:0]         reg_ip,
  input  logic [OFS_W-1:0]         reg_sp,
  input  logic                     ovr_en,
  input  logic [1:0]               ovr_sel,
  output logic [OFS_W+SHIFT-1:0]   phys_addr,
  output logic [OFS_W-1:0]         eff_addr,
  output logic                     bad_mode
);
  localparam int PA_W = OFS_W + SHIFT;
  localparam logic [1:0] SG_EXT = 2'd0, SG_COD = 2'd1, SG_STK = 2'd2, SG_DAT = 2'd3;

  logic [OFS_W-1:0] seg_q [4];
  logic [OFS_W-1:0] val_a, val_b, off;
  logic [1:0]       sel;
  logic             bad;
  logic [PA_W-1:0]  pa;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) seg_q[i] <= '0;
    end else if (seg_wr_en) begin
      seg_q[seg_wr_sel] <= seg_wr_data;
    end
  end

  function automatic logic [OFS_W-1:0] opval(input logic [2:0] c);
    case (c)
      3'd1:    return reg_gbase;
      3'd2:    return reg_fbase;
      3'd3:    return reg_sidx;
      3'd4:    return reg_didx;
      default: return '0;
    endcase
  endfunction

  function automatic logic is_base(input logic [2:0] c);
    return (c == 3'd1) || (c == 3'd2);
  endfunction

  function automatic logic is_idx(input logic [2:0] c);
    return (c == 3'd3) || (c == 3'd4);
  endfunction

  assign val_a = opval(op_a);
  assign val_b = opval(op_b);

  always_comb begin
    bad = 1'b0;
    case (kind)
      2'd1: begin off = reg_ip;   sel = SG_COD; end
      2'd2: begin off = reg_sp;   sel = SG_STK; end
      2'd3: begin off = reg_didx; sel = SG_EXT; end
      default: begin
        off = val_a + val_b + (disp_en ? disp : '0);
        sel = (op_a == 3'd2 || op_b == 3'd2) ? SG_STK : SG_DAT;
        if (ovr_en) sel = ovr_sel;
        bad = (is_base(op_a) && is_base(op_b)) || (is_idx(op_a) && is_idx(op_b));
      end
    endcase
  end

  assign pa = {seg_q[sel], {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, off};

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      eff_addr  <= '0;
      bad_mode  <= 1'b0;
    end else begin
      phys_addr <= bad ? '0 : pa;
      eff_addr  <= bad ? '0 : off;
      bad_mode  <= bad;
    end
  end

  logic run_q;
  always_ff @(posedge clk) run_q <= !rst;

  assert_bad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    bad_mode |-> (phys_addr == '0 && eff_addr == '0));
  assert_fetch_ip_R6: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(kind) == 2'd1) |-> (eff_addr == $past(reg_ip) && !bad_mode));
  assert_stack_sp_R7: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(kind) == 2'd2) |-> (eff_addr == $past(reg_sp) && !bad_mode));
  assert_strdst_di_R8: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(kind) == 2'd3) |-> (eff_addr == $past(reg_didx) && !bad_mode));
  assert_seg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (run_q && !$past(seg_wr_en)) |-> (seg_q[1] == $past(seg_q[1]) && seg_q[2] == $past(seg_q[2])));
endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  logic clk = 1'b0, rst = 1'b1;
  logic seg_wr_en = 1'b0;
  logic [1:0] seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic [1:0] kind = '0;
  logic [2:0] op_a = '0, op_b = '0;
  logic disp_en = 1'b0;
  logic [15:0] disp = '0, reg_gbase = '0, reg_fbase = '0, reg_sidx = '0, reg_didx = '0, reg_ip = '0, reg_sp = '0;
  logic ovr_en = 1'b0;
  logic [1:0] ovr_sel = '0;
  logic [19:0] phys_addr;
  logic [15:0] eff_addr;
  logic bad_mode;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic clear_req();
    kind = 0; op_a = 0; op_b = 0; disp_en = 0; disp = 0; ovr_en = 0; ovr_sel = 0;
  endtask

  task automatic wrseg(input logic [1:0] s, input logic [15:0] v);
    seg_wr_en = 1; seg_wr_sel = s; seg_wr_data = v; tick(); seg_wr_en = 0;
  endtask

  task automatic t_reset();
    chk("R10 phys", phys_addr, 0); chk("R10 eff", eff_addr, 0); chk("R10 bad", bad_mode, 0);
    clear_req(); disp_en = 1; disp = 16'h0040; tick();
    chk("R10 seg cleared", phys_addr, 20'h00040);
  endtask

  task automatic t_fetch();
    wrseg(1, 16'h448A);
    clear_req(); kind = 1; reg_ip = 16'h1234; ovr_en = 1; ovr_sel = 3; tick();
    chk("R6 fetch phys", phys_addr, 20'h45AD4); chk("R6 fetch bad", bad_mode, 0);
  endtask

  task automatic t_stack();
    wrseg(2, 16'h6000);
    clear_req(); kind = 2; reg_sp = 16'h0010; ovr_en = 1; ovr_sel = 0; tick();
    chk("R7 stack phys", phys_addr, 20'h60010); chk("R1 stack eff", eff_addr, 16'h0010);
  endtask

  task automatic t_data_default();
    wrseg(3, 16'h1000);
    clear_req(); op_a = 1; op_b = 3; reg_gbase = 16'hFFF0; reg_sidx = 16'h0020; tick();
    chk("R2 ea wrap", eff_addr, 16'h0010); chk("R3 data seg", phys_addr, 20'h10010);
    clear_req(); op_a = 4; op_b = 2; disp_en = 1; disp = 16'h0003;
    reg_fbase = 16'h0100; reg_didx = 16'h0002; tick();
    chk("R3 frame to stack", phys_addr, 20'h60105); chk("R2 ea sum", eff_addr, 16'h0105);
  endtask

  task automatic t_override();
    wrseg(0, 16'h2000);
    clear_req(); op_a = 2; op_b = 4; disp_en = 1; disp = 16'h0003; ovr_en = 1; ovr_sel = 0; tick();
    chk("R4 override extra", phys_addr, 20'h20105);
    clear_req(); kind = 3; reg_didx = 16'h0002; ovr_en = 1; ovr_sel = 3; tick();
    chk("R8 strdst phys", phys_addr, 20'h20002);
  endtask

  task automatic t_illegal();
    clear_req(); op_a = 1; op_b = 2; tick();
    chk("R5 base pair flag", bad_mode, 1); chk("R5 base pair phys", phys_addr, 0);
    clear_req(); op_a = 3; op_b = 4; disp_en = 1; disp = 16'h0011; tick();
    chk("R5 idx pair flag", bad_mode, 1); chk("R5 idx pair eff", eff_addr, 0);
    clear_req(); op_a = 3; tick();
    chk("R5 legal clears flag", bad_mode, 0);
  endtask

  task automatic t_wrap();
    wrseg(3, 16'hFFFF);
    clear_req(); disp_en = 1; disp = 16'hFFFF; tick();
    chk("R1 20-bit wrap", phys_addr, 20'h0FFEF);
  endtask

  task automatic t_write_timing();
    clear_req(); disp_en = 1; disp = 16'h0000;
    seg_wr_en = 1; seg_wr_sel = 3; seg_wr_data = 16'h5000; tick(); seg_wr_en = 0;
    chk("R9 same-cycle old", phys_addr, 20'hFFFF0);
    tick();
    chk("R9 next-cycle new", phys_addr, 20'h50000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset(); t_fetch(); t_stack(); t_data_default(); t_override();
    t_illegal(); t_wrap(); t_write_timing();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule